// File: doc/BRIEF.md
# Serial Transmit Path with Line-Status Flags

This block is the transmit half of a 16550-class serial port, together with the line-status bits that describe it. The CPU writes characters into a single holding register or, with queueing switched on, into a 16-entry transmit queue. A shift register turns each character into a serial frame, advancing one bit per baud tick. The block reports two read-only flags: one says the port can take another character, and the other says that both the holding stage and the shifter are empty. An interrupt request follows the first flag whenever its enable is set.

The same block also holds the receive-error summary bit of the line-status register. A receive queue model reports, for each entry it pushes or pops, whether that entry carries a parity, framing or break error. The summary bit keeps a record of those errors until software reads the line status.

Switching the queueing mode discards any characters that are waiting and clears the receive error record. A frame already in the shifter finishes normally.

Top module: `uart_tx_status`

## Requirements
- R1: With queueing off, `thre` drops to 0 on the clock edge that takes a `thr_wr` and returns to 1 on the edge where the shifter takes the held character. A write on that same edge replaces the held character, and `thre` stays 0.
- R2: With queueing on, `thre` is 1 exactly when the transmit queue holds no entries. It goes to 0 on the edge that accepts a write.
- R3: `thre_irq` is high exactly when `thre` is 1 and `thre_ie` is 1.
- R4: `temt` is 1 only when the holding stage (register or queue) is empty and the shifter is idle. It is 0 whenever either stage holds a character.
- R5: An idle shifter that has a character waiting loads it on the next `baud_tick`. From the next cycle, `txd` presents a 0 start bit, then the 8 data bits LSB first, then a 1 stop bit. Each bit lasts until the following `baud_tick`. After the stop bit's tick the shifter is idle, and `txd` rests at 1.
- R6: `rx_err_sum` is 0 whenever queueing is off. On the edge after `fifo_en` is sampled low, it is 0.
- R7: With queueing on, `rx_err_sum` is set once any entry tagged with an error is in the receive queue. It stays set after those entries leave. An `lsr_rd` clears it only if no error-tagged entries remain in the queue at that edge.
- R8: After reset, `thre`=1, `temt`=1, `txd`=1 and `rx_err_sum`=0.
- R9: The transmit queue holds 16 characters. A write while it is full is discarded, and the 16 stored characters are sent in write order.
- R10: A change of `fifo_en` takes effect on the next edge. On that edge the pending transmit characters and the receive error record are discarded, and writes presented in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Queueing mode enable |
| thr_wr | input | 1 | Write strobe for the holding stage |
| thr_data | input | 8 | Character to transmit |
| thre_ie | input | 1 | Enable for the holding-empty interrupt |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| rx_push | input | 1 | Receive queue model pushed an entry |
| rx_push_err | input | 1 | Pushed entry carries an error tag |
| rx_pop | input | 1 | Receive queue model popped an entry |
| rx_pop_err | input | 1 | Popped entry carried an error tag |
| lsr_rd | input | 1 | Line-status register read strobe |
| txd | output | 1 | Serial output |
| thre | output | 1 | Holding stage empty flag |
| temt | output | 1 | Transmitter fully empty flag |
| thre_irq | output | 1 | Holding-empty interrupt request |
| rx_err_sum | output | 1 | Receive error summary bit |

## Verification
Every flag and `txd` comes from state that changes on the same edge that samples the stimulus. A write, a tick, a status read or a mode change therefore shows up one edge later. The exception is `thre_irq`, which also follows `thre_ie` within the same cycle. The bench drives inputs at the falling edge and advances its model at the rising edge. It compares all five outputs 1 ns after that rising edge, so each result is checked in exactly the cycle it becomes due. Frame checks decode `txd` with a tick every cycle and expect a start bit one cycle after the loading tick.

// File: rtl/uart_tx_status.sv
module uart_tx_status #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             thr_wr,
  input  logic [WIDTH-1:0] thr_data,
  input  logic             thre_ie,
  input  logic             baud_tick,
  input  logic             rx_push,
  input  logic             rx_push_err,
  input  logic             rx_pop,
  input  logic             rx_pop_err,
  input  logic             lsr_rd,
  output logic             txd,
  output logic             thre,
  output logic             temt,
  output logic             thre_irq,
  output logic             rx_err_sum
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int FRAME = WIDTH + 2;
  localparam int BW    = $clog2(FRAME);

  logic             mode_q;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [AW:0]      count;
  logic [WIDTH-1:0] hold_q;
  logic             hold_v;
  logic             busy;
  logic [FRAME-1:0] shreg;
  logic [BW-1:0]    bitcnt;
  logic [CW-1:0]    errcnt, errcnt_n;
  logic             err_q;

  wire flush = fifo_en != mode_q;
  wire avail = mode_q ? (count != '0) : hold_v;
  wire [WIDTH-1:0] head = mode_q ? mem[rptr] : hold_q;
  wire load  = baud_tick && !busy && avail && !flush;
  wire push  = thr_wr && mode_q && !flush && (count < (AW+1)'(DEPTH));
  wire pop   = load && mode_q;
  wire hwr   = thr_wr && !mode_q && !flush;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_en;

  always_ff @(posedge clk) if (push) mem[wptr] <= thr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
    end else if (flush) begin
      hold_v <= 1'b0;
    end else if (!mode_q) begin
      if (hwr) hold_q <= thr_data;
      hold_v <= hwr || (hold_v && !load);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      shreg  <= '1;
      bitcnt <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      shreg  <= {1'b1, head, 1'b0};
      bitcnt <= '0;
    end else if (busy && baud_tick) begin
      if (bitcnt == BW'(FRAME - 1)) begin
        busy <= 1'b0;
      end else begin
        shreg  <= {1'b1, shreg[FRAME-1:1]};
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  always_comb begin
    errcnt_n = errcnt;
    if (rx_push && rx_push_err && errcnt != CW'(DEPTH)) errcnt_n = errcnt_n + 1'b1;
    if (rx_pop && rx_pop_err && errcnt_n != '0)        errcnt_n = errcnt_n - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errcnt <= '0;
      err_q  <= 1'b0;
    end else if (!fifo_en || flush) begin
      errcnt <= '0;
      err_q  <= 1'b0;
    end else begin
      errcnt <= errcnt_n;
      err_q  <= (errcnt_n != '0) || (err_q && !lsr_rd);
    end
  end

  assign txd        = busy ? shreg[0] : 1'b1;
  assign thre       = !avail;
  assign temt       = !avail && !busy;
  assign thre_irq   = thre && thre_ie;
  assign rx_err_sum = err_q;
endmodule

// File: rtl/uart_tx_status_chk.sv
module uart_tx_status_chk #(
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     fifo_en,
  input logic                     thr_wr,
  input logic                     thre_ie,
  input logic                     thre,
  input logic                     temt,
  input logic                     txd,
  input logic                     thre_irq,
  input logic                     rx_err_sum,
  input logic                     mode_q,
  input logic [$clog2(DEPTH):0]   count
);
  assert_hold_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !mode_q && thr_wr) |=> !thre);
  assert_queue_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && mode_q && thr_wr) |=> !thre);
  assert_irq_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    thre_irq |-> (thre && thre_ie));
  assert_temt_implies_thre_R4: assert property (@(posedge clk) disable iff (!rst_n)
    temt |-> thre);
  assert_idle_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    temt |-> txd);
  assert_err_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> !rx_err_sum);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH)+1)'(DEPTH));
endmodule

bind uart_tx_status uart_tx_status_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_tx_status_tb.sv
module uart_tx_status_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 0, thr_wr = 0, thre_ie = 0, baud_tick = 0;
  logic rx_push = 0, rx_push_err = 0, rx_pop = 0, rx_pop_err = 0, lsr_rd = 0;
  logic [7:0] thr_data = 0;
  logic txd, thre, temt, thre_irq, rx_err_sum;

  int nvec = 0, nbad = 0;

  logic       mmode = 0, mhold_v = 0, mbusy = 0, merr = 0;
  logic [7:0] mhold = 0;
  logic [9:0] msh = '1;
  int         mbit = 0;
  logic [7:0] q[$];
  logic       rxq[$];

  uart_tx_status u_dut (.*);

  always #10 clk = ~clk;

  initial begin
    #(20ns * 200000);
    nbad++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  function automatic logic exp_thre();
    return mmode ? (q.size() == 0) : !mhold_v;
  endfunction

  function automatic int rx_errs();
    int n = 0;
    foreach (rxq[i]) n += rxq[i];
    return n;
  endfunction

  task automatic compare();
    chk(mmode ? "R2 thre" : "R1 thre", thre, exp_thre());
    chk("R4 temt", temt, exp_thre() && !mbusy);
    chk("R5 txd", txd, mbusy ? msh[0] : 1'b1);
    chk("R3 thre_irq", thre_irq, exp_thre() && thre_ie);
    chk(mmode ? "R7 rx_err_sum" : "R6 rx_err_sum", rx_err_sum, merr);
  endtask

  task automatic step(input logic fe, input logic wr, input logic [7:0] d, input logic ie,
                      input logic tk, input logic lsr, input logic rpush, input logic rperr,
                      input logic rpop);
    logic flush, avail, load, push, pop_err;
    logic [7:0] head;
    @(negedge clk);
    pop_err = (rpop && rxq.size() > 0) ? rxq[0] : 1'b0;
    fifo_en = fe; thr_wr = wr; thr_data = d; thre_ie = ie; baud_tick = tk;
    lsr_rd = lsr; rx_push = rpush; rx_push_err = rperr;
    rx_pop = rpop && rxq.size() > 0; rx_pop_err = pop_err;
    @(posedge clk);
    flush = fe != mmode;
    avail = !exp_thre();
    head  = mmode ? (q.size() > 0 ? q[0] : 8'h00) : mhold;
    load  = tk && !mbusy && avail && !flush;
    push  = wr && mmode && !flush && q.size() < 16;
    if (load) begin
      msh = {1'b1, head, 1'b0}; mbusy = 1; mbit = 0;
    end else if (mbusy && tk) begin
      if (mbit == 9) mbusy = 0;
      else begin msh = {1'b1, msh[9:1]}; mbit++; end
    end
    if (flush) begin
      q.delete(); mhold_v = 0;
    end else if (mmode) begin
      if (load) void'(q.pop_front());
      if (push) q.push_back(d);
    end else begin
      if (wr) mhold = d;
      mhold_v = wr || (mhold_v && !load);
    end
    if (!fe || flush) begin
      rxq.delete(); merr = 0;
    end else begin
      if (rpush) rxq.push_back(rperr);
      if (rx_pop) void'(rxq.pop_front());
      merr = (rx_errs() != 0) || (merr && !lsr);
    end
    mmode = fe;
    #1;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(mmode, 0, 0, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic drain_frames(input int exp_n, input logic [7:0] expd[$]);
    int got = 0, guard = 0;
    logic [7:0] b;
    while (!(thre && temt) && guard < 400) begin
      step(mmode, 0, 0, 0, 1, 0, 0, 0, 0); guard++;
      if (txd == 1'b0) begin
        for (int k = 0; k < 8; k++) begin
          step(mmode, 0, 0, 0, 1, 0, 0, 0, 0); guard++;
          b[k] = txd;
        end
        step(mmode, 0, 0, 0, 1, 0, 0, 0, 0); guard++;
        chk("R5 stop bit", txd, 1'b1);
        chk("R9 frame data order", b == expd[got], 1'b1);
        got++;
      end
    end
    nvec++;
    if (got != exp_n) begin
      nbad++;
      $display("FAIL R9 frame count: actual %0d expected %0d", got, exp_n);
    end
  endtask

  initial begin
    logic [7:0] sent[$];
    #35;
    // R8: reset state
    chk("R8 thre", thre, 1'b1);
    chk("R8 temt", temt, 1'b1);
    chk("R8 txd", txd, 1'b1);
    chk("R8 rx_err_sum", rx_err_sum, 1'b0);
    rst_n = 1'b1;
    idle(3);

    // R1/R5: single char in holding mode, overwrite before load
    step(0, 1, 8'h3C, 1, 0, 0, 0, 0, 0);
    step(0, 1, 8'hA5, 1, 0, 0, 0, 0, 0);
    sent = '{8'hA5};
    drain_frames(1, sent);

    // R10: enter queueing mode with a write in the switch cycle (ignored)
    step(1, 1, 8'h11, 1, 0, 0, 0, 0, 0);
    chk("R10 write dropped on switch", thre, 1'b1);
    // R9: 17 writes, last dropped
    sent.delete();
    for (int i = 0; i < 17; i++) begin
      step(1, 1, 8'(i * 13 + 7), 1, 0, 0, 0, 0, 0);
      if (i < 16) sent.push_back(8'(i * 13 + 7));
    end
    drain_frames(16, sent);

    // R7: sticky error directed cases
    step(1, 0, 0, 0, 0, 0, 1, 1, 0);
    step(1, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R7 sticky after pop", rx_err_sum, 1'b1);
    step(1, 0, 0, 0, 0, 1, 1, 1, 0);
    chk("R7 read with error pending", rx_err_sum, 1'b1);
    step(1, 0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R7 read clears", rx_err_sum, 1'b0);

    // R10: pending chars discarded on switch back
    step(1, 1, 8'h55, 1, 0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R10 flush", thre, 1'b1);
    chk("R6 err cleared", rx_err_sum, 1'b0);

    // random phases
    void'($urandom(32'h1234_5678));
    for (int ph = 0; ph < 4; ph++) begin
      logic fe = ph[0];
      for (int i = 0; i < 2500; i++) begin
        logic rp = fe && ($urandom % 5 == 0) && rxq.size() < 16;
        step(($urandom % 600 == 0) ? !fe : fe,
             $urandom % 7 == 0, 8'($urandom), $urandom % 2,
             $urandom % 3 == 0, $urandom % 8 == 0,
             rp, $urandom % 3 == 0, fe && ($urandom % 5 == 0));
        if (mmode != fe) step(fe, 0, 0, 0, 0, 0, 0, 0, 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule